// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block holds the run/stop state of up to sixty-four peripheral clocks. It drives one gated-clock enable per peripheral. The enables are arranged as two groups of thirty-two. Software turns clocks on through a set register and off through a separate clear register, and it reads the live state from a status register. Because of this, no read-modify-write sequence is ever needed. Bit *i* of group *g* controls the peripheral whose identifier is 32·g + i, which is also that peripheral's interrupt number.

Each enable output is taken directly from a state flop. It stops on the edge that captures the clear write, with no drain or handshake. Identifiers that are not built are tied off by a parameter mask.

The actual clock-gating cells sit outside the block. Each one is controlled by the corresponding `clk_en_o` bit.

Top module: `periph_clk_gate_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, every `clk_en_o` bit is 0 and both status registers read 0.
- R2: A write to a set register (group 0 at 0x00, group 1 at 0x10) turns on every peripheral whose data bit is 1. Data bits that are 0 leave their peripheral unchanged.
- R3: A write to a clear register (group 0 at 0x04, group 1 at 0x14) turns off every peripheral whose data bit is 1. Data bits that are 0 leave their peripheral unchanged.
- R4: Reading 0x08 returns `clk_en_o[31:0]` and reading 0x18 returns `clk_en_o[63:32]`, with bit i of group g equal to peripheral 32·g+i. Reads are combinational from `reg_addr`.
- R5: Set and clear registers, the reserved offsets 0x0C and 0x1C, addresses with non-zero bits [1:0], and addresses at 0x20 and above all read as zero.
- R6: Identifiers whose bit in `IMPL_MASK` is 0 always show 0 on `clk_en_o` and in status, even after a set write. The default mask leaves identifiers 60 to 63 unimplemented.
- R7: Each enable is registered. It keeps its old value while a write is presented and takes the new value on the rising edge that captures the write. A clear stops the clock at that same edge.
- R8: With `reg_we` low, or with a write to a status, reserved or unmapped address, no enable changes.
- R9: A write to one group leaves every enable of the other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| clk_en_o | output | 64 | Per-peripheral gated-clock enable, index = identifier |

## Verification
The set and clear registers are driven with all-ones, all-zeros, single-bit and random data. All-zeros shows that unset bits are ignored. Single bits expose a wrong index or a swapped group. All-ones applied to the tied-off identifiers shows whether the mask is honoured. Writes with the strobe low, writes to status, reserved and unaligned addresses, and writes beyond the map are mixed in to separate a true no-op from a stray update. Each write is checked both before and after its capturing edge, which tells a registered enable from a combinational one.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;

  // Register kinds selected by address bits [3:2]
  typedef enum logic [1:0] {
    RK_SET  = 2'b00,
    RK_CLR  = 2'b01,
    RK_STAT = 2'b10,
    RK_RSVD = 2'b11
  } reg_kind_e;

  localparam int KIND_LSB = 2;
  localparam int GRP_LSB  = 4;

  function automatic reg_kind_e kind_of(input logic [1:0] field);
    return reg_kind_e'(field);
  endfunction

  // Next state of one group: clear beats set, unbuilt bits forced low
  function automatic logic [31:0] next_run(input logic [31:0] cur,
                                           input logic [31:0] set_b,
                                           input logic [31:0] clr_b,
                                           input logic [31:0] impl);
    return ((cur | set_b) & ~clr_b) & impl;
  endfunction

endpackage

// File: rtl/pcg_decode.sv
`timescale 1ns/1ps
module pcg_decode #(
  parameter int ADDR_W  = 8,
  parameter int NUM_GRP = 2,
  parameter int REG_W   = 32,
  localparam int GSEL_W = ADDR_W - pcg_pkg::GRP_LSB
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we,
  input  logic [REG_W-1:0]         wdata,
  output logic [NUM_GRP*REG_W-1:0] set_vec,
  output logic [NUM_GRP*REG_W-1:0] clr_vec,
  output logic                     rd_hit,
  output logic [GSEL_W-1:0]        rd_grp
);
  import pcg_pkg::*;

  logic [GSEL_W-1:0] grp;
  logic [1:0]        align;
  reg_kind_e         kind;
  logic              mapped;

  assign grp    = addr[ADDR_W-1:GRP_LSB];
  assign align  = addr[KIND_LSB-1:0];
  assign kind   = kind_of(addr[GRP_LSB-1:KIND_LSB]);
  assign mapped = (align == 2'b00) && (int'(grp) < NUM_GRP);
  assign rd_hit = mapped && (kind == RK_STAT);
  assign rd_grp = grp;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic sel;
    assign sel = we && mapped && (grp == GSEL_W'(g));
    assign set_vec[g*REG_W +: REG_W] = (sel && kind == RK_SET) ? wdata : '0;
    assign clr_vec[g*REG_W +: REG_W] = (sel && kind == RK_CLR) ? wdata : '0;
  end

endmodule

// File: rtl/pcg_bank.sv
`timescale 1ns/1ps
module pcg_bank #(
  parameter int               REG_W = 32,
  parameter logic [REG_W-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_bits,
  input  logic [REG_W-1:0] clr_bits,
  output logic [REG_W-1:0] run
);
  import pcg_pkg::*;

  logic [REG_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= next_run(run_q, set_bits, clr_bits, IMPL);
  end

  assign run = run_q;

endmodule

// File: rtl/pcg_rdmux.sv
`timescale 1ns/1ps
module pcg_rdmux #(
  parameter int NUM_GRP = 2,
  parameter int REG_W   = 32,
  parameter int GSEL_W  = 4
) (
  input  logic [NUM_GRP*REG_W-1:0] run_all,
  input  logic                     rd_hit,
  input  logic [GSEL_W-1:0]        rd_grp,
  output logic [REG_W-1:0]         rdata
);
  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (rd_hit && rd_grp == GSEL_W'(g)) rdata = run_all[g*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/periph_clk_gate_ctrl.sv
`timescale 1ns/1ps
module periph_clk_gate_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int NUM_GRP = 2,
  parameter int REG_W   = 32,
  parameter logic [NUM_GRP*REG_W-1:0] IMPL_MASK = 64'h0FFF_FFFF_FFFF_FFFF,
  localparam int NUM_ID = NUM_GRP * REG_W,
  localparam int GSEL_W = ADDR_W - pcg_pkg::GRP_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NUM_ID-1:0] clk_en_o
);

  // Named internal events for the checker
  logic [NUM_ID-1:0] set_vec;
  logic [NUM_ID-1:0] clr_vec;
  logic              rd_hit;
  logic [GSEL_W-1:0] rd_grp;
  logic [NUM_ID-1:0] run_all;

  pcg_decode #(.ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP), .REG_W(REG_W)) u_dec (
    .addr    (reg_addr),
    .we      (reg_we),
    .wdata   (reg_wdata),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .rd_hit  (rd_hit),
    .rd_grp  (rd_grp)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    pcg_bank #(.REG_W(REG_W), .IMPL(IMPL_MASK[g*REG_W +: REG_W])) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (set_vec[g*REG_W +: REG_W]),
      .clr_bits (clr_vec[g*REG_W +: REG_W]),
      .run      (run_all[g*REG_W +: REG_W])
    );
  end

  pcg_rdmux #(.NUM_GRP(NUM_GRP), .REG_W(REG_W), .GSEL_W(GSEL_W)) u_rd (
    .run_all (run_all),
    .rd_hit  (rd_hit),
    .rd_grp  (rd_grp),
    .rdata   (reg_rdata)
  );

  assign clk_en_o = run_all;

endmodule

// File: rtl/pcg_checker.sv
`timescale 1ns/1ps
module pcg_checker #(
  parameter int ADDR_W  = 8,
  parameter int NUM_GRP = 2,
  parameter int REG_W   = 32,
  parameter logic [NUM_GRP*REG_W-1:0] IMPL_MASK = '1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic                     reg_we,
  input logic [REG_W-1:0]         reg_rdata,
  input logic [NUM_GRP*REG_W-1:0] clk_en_o,
  input logic [NUM_GRP*REG_W-1:0] set_vec,
  input logic [NUM_GRP*REG_W-1:0] clr_vec
);
  localparam int NUM_ID = NUM_GRP * REG_W;
  logic [NUM_ID-1:0] eff_set;
  assign eff_set = set_vec & IMPL_MASK & ~clr_vec;

  // R1: flops held off during reset
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_off: assert (clk_en_o == '0);
  end

  // R2: set bits are running one edge later, running bits stay unless cleared
  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((clk_en_o & $past(eff_set)) == $past(eff_set)));
  a_r2_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((clk_en_o | $past(clr_vec)) & $past(clk_en_o)) == $past(clk_en_o));

  // R3: cleared bits are off at the capturing edge
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((clk_en_o & $past(clr_vec)) == '0));

  // R6: unbuilt identifiers never run
  a_r6_tied_off: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_o & ~IMPL_MASK) == '0);

  // R8: no strobe means no update
  a_r8_no_write_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |-> (set_vec == '0 && clr_vec == '0));
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(clk_en_o));

  // R4: status reads mirror the enables; R5: other offsets read zero
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_rd
    a_r4_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(g*16 + 8)) |-> (reg_rdata == clk_en_o[g*REG_W +: REG_W]));
  end
  a_r5_others_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[3:0] != 4'h8) |-> (reg_rdata == '0));

endmodule

bind periph_clk_gate_ctrl pcg_checker #(
  .ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP), .REG_W(REG_W), .IMPL_MASK(IMPL_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata),
  .clk_en_o  (clk_en_o),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec)
);

// File: tb/periph_clk_gate_ctrl_tb.sv
`timescale 1ns/1ps
module periph_clk_gate_ctrl_tb;

  localparam logic [63:0] BUILT = 64'h0FFF_FFFF_FFFF_FFFF; // R6: ids 60..63 absent

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [63:0] clk_en_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [63:0] model = 64'h0;

  always #5 clk = ~clk;

  periph_clk_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .clk_en_o(clk_en_o)
  );

  // Reference: new state after one write, written per address
  function automatic logic [63:0] apply_write(input logic [63:0] m,
                                              input logic [7:0] a,
                                              input logic [31:0] d,
                                              input logic we);
    logic [63:0] r;
    r = m;
    if (we) begin
      case (a)
        8'h00: r = m | ({32'h0, d} & BUILT);
        8'h10: r = m | ({d, 32'h0} & BUILT);
        8'h04: r = m & ~{32'h0, d};
        8'h14: r = m & ~{d, 32'h0};
        default: r = m;
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] expect_read(input logic [63:0] m, input logic [7:0] a);
    if (a == 8'h08) return m[31:0];
    if (a == 8'h18) return m[63:32];
    return 32'h0;
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle; checks the enables before and after the capturing edge
  task automatic bus_write(input string req, input logic [7:0] a,
                           input logic [31:0] d, input logic we);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = we;
    #1;
    check64("R7 hold before edge", clk_en_o, model);
    model = apply_write(model, a, d, we);
    @(negedge clk);
    reg_we = 1'b0;
    check64(req, clk_en_o, model);
  endtask

  task automatic bus_read(input string req, input logic [7:0] a);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1;
    check32(req, reg_rdata, expect_read(model, a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [10];
    void'($urandom(32'd20240611));
    addrs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h0C, 8'h1C, 8'h21, 8'h24};

    repeat (3) @(posedge clk);
    @(negedge clk);
    check64("R1 enables in reset", clk_en_o, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R1 enables after reset", clk_en_o, 64'h0);
    bus_read("R1 status0 after reset", 8'h08);
    bus_read("R1 status1 after reset", 8'h18);

    // Directed corners
    bus_write("R2 set all group0", 8'h00, 32'hFFFF_FFFF, 1'b1);
    bus_write("R9 group1 untouched", 8'h00, 32'h0, 1'b1);
    bus_write("R2 set all group1 with tie-off R6", 8'h10, 32'hFFFF_FFFF, 1'b1);
    check64("R6 ids 60..63 off", clk_en_o & ~BUILT, 64'h0);
    bus_read("R6 status1 tie-off", 8'h18);
    bus_write("R3 zero clear no effect", 8'h04, 32'h0, 1'b1);
    bus_write("R3 clear single bit 5", 8'h04, 32'h0000_0020, 1'b1);
    bus_write("R9 clear group1 bit 0 only", 8'h14, 32'h0000_0001, 1'b1);
    bus_write("R8 strobe low on clear", 8'h04, 32'hFFFF_FFFF, 1'b0);
    bus_write("R8 write to status", 8'h08, 32'h0, 1'b1);
    bus_write("R8 unaligned clear", 8'h06, 32'hFFFF_FFFF, 1'b1);
    bus_write("R8 beyond map", 8'h24, 32'hFFFF_FFFF, 1'b1);
    bus_read("R4 status0", 8'h08);
    bus_read("R4 status1", 8'h18);
    bus_read("R5 set reg reads zero", 8'h00);
    bus_read("R5 clear reg reads zero", 8'h14);
    bus_read("R5 reserved reads zero", 8'h1C);
    bus_read("R5 unaligned reads zero", 8'h0A);
    bus_write("R3 clear all group1", 8'h14, 32'hFFFF_FFFF, 1'b1);
    bus_write("R2 set single id 31", 8'h00, 32'h8000_0000, 1'b1);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic        w;
      int sel;
      sel = $urandom_range(0, 9);
      a = (($urandom_range(0, 7)) == 0) ? 8'($urandom) : addrs[sel];
      case ($urandom_range(0, 3))
        0: d = 32'h1 << $urandom_range(0, 31);
        1: d = 32'hFFFF_FFFF;
        default: d = $urandom;
      endcase
      w = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 2) == 0) bus_read("R4 R5 random read", a);
      else bus_write("R2 R3 R8 R9 random write", a, d, w);
    end
    bus_read("R4 final status0", 8'h08);
    bus_read("R4 final status1", 8'h18);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule